// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block checks a pair of identical processor cores that execute one instruction stream in lockstep. One core is the master. The other is the checker, and it runs a fixed `DLY` cycles behind the master. The block passes the stimulus meant for the checker core through a `DLY`-stage register delay line. It sends the master's observed outputs and internal state through a matching delay line. After that, both streams describe the same instruction cycle, and the block compares them bit for bit in every cycle.

The first `DLY` cycles after reset are masked, because the delay lines do not yet hold valid data. After that window, a difference in any single bit puts the block into a safe state in the same cycle. The actuator drive output is forced to zero and a sticky error flag is set. The block also records the cycle index and the lowest differing bit of the first mismatch, for later diagnosis. Only reset clears the error flag, the safe state and the record.

Top module: `lockstep_cmp`

## Requirements
- R1: `chk_stim_o` equals the `stim_i` value from exactly `DLY` cycles earlier. During the first `DLY` cycles after reset it is zero.
- R2: In cycle t (with t >= `DLY`), the `mst_obs_i` value from cycle t-`DLY` is compared with the current `chk_obs_i`. A difference in any one bit counts as a mismatch.
- R3: No mismatch is acted on in cycles 0 to `DLY`-1 after reset release, whatever the inputs are.
- R4: `safe_o` goes high in the same cycle as the first acted-on mismatch. While `safe_o` is high, `act_o` is all zeros. While it is low, `act_o` equals `act_i`.
- R5: `err_o` goes high at the clock edge that ends the mismatching cycle. After that, `err_o` and `safe_o` stay high until reset.
- R6: `fault_cycle_o` holds the index of the first mismatching cycle. Cycle 0 is the cycle between reset release and the first rising edge, and each rising edge adds one. The count saturates at its maximum.
- R7: `fault_bit_o` holds the lowest bit index that differed in the first mismatch. Later mismatches change neither `fault_bit_o` nor `fault_cycle_o`. Both read zero while no fault has been recorded.
- R8: Reset clears `err_o`, `safe_o`, the fault record and both delay lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stim_i | input | IN_W | Stimulus applied to the master core |
| chk_stim_o | output | IN_W | Stimulus for the checker core, delayed DLY cycles |
| mst_obs_i | input | OBS_W | Master outputs and internal state |
| chk_obs_i | input | OBS_W | Checker outputs and internal state |
| act_i | input | ACT_W | Actuator drive request |
| act_o | output | ACT_W | Actuator drive, zero while in the safe state |
| safe_o | output | 1 | Safe state active (combinational on the first mismatch) |
| err_o | output | 1 | Sticky lockstep error |
| fault_cycle_o | output | CNT_W | Cycle index of the first mismatch |
| fault_bit_o | output | BIT_W | Lowest differing bit of the first mismatch |

## Verification
The assertions assume that `DLY` stays small (2 or 3), which makes it a safe `$past` depth. They also assume that the inputs are stable around each rising edge. The bench models both cores as the same accumulator. The master core reads `stim_i` and the checker core reads `chk_stim_o`, so the aligned streams agree unless the bench injects a fault. The bench drives every input at the falling edge. It forces a fault only by XOR-ing a chosen bit mask onto `chk_obs_i` for exactly one cycle, so each mismatch has a known cycle index and bit position.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  typedef enum logic [1:0] {
    LS_FILL = 2'd0,
    LS_RUN  = 2'd1,
    LS_SAFE = 2'd2
  } ls_state_e;
endpackage

// File: rtl/ls_delay_line.sv
module ls_delay_line #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [N];

  for (genvar s = 0; s < N; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[N-1];
endmodule

// File: rtl/ls_diff_locate.sv
module ls_diff_locate #(
  parameter int W = 8,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic          any_o,
  output logic [BW-1:0] pos_o
);
  logic [W-1:0] diff;
  assign diff  = a_i ^ b_i;
  assign any_o = |diff;

  // descending scan, lowest set bit wins
  always_comb begin
    pos_o = '0;
    for (int i = W-1; i >= 0; i--) begin
      if (diff[i]) pos_o = BW'(i);
    end
  end
endmodule

// File: rtl/ls_fault_latch.sv
module ls_fault_latch
  import lockstep_pkg::*;
#(
  parameter int DLY   = 2,
  parameter int CNT_W = 16,
  parameter int BW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mis_i,
  input  logic [BW-1:0]    pos_i,
  output logic             safe_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic [BW-1:0]    bit_o
);
  ls_state_e        st_q;
  logic [CNT_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != '1) cyc_q <= cyc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LS_FILL;
      cyc_o <= '0;
      bit_o <= '0;
    end else begin
      unique case (st_q)
        LS_FILL: if (cyc_q == CNT_W'(DLY-1)) st_q <= LS_RUN;
        LS_RUN: if (mis_i) begin
          st_q  <= LS_SAFE;
          cyc_o <= cyc_q;
          bit_o <= pos_i;
        end
        default: st_q <= LS_SAFE;
      endcase
    end
  end

  assign err_o  = (st_q == LS_SAFE);
  assign safe_o = err_o || ((st_q == LS_RUN) && mis_i);
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
  parameter int DLY   = 2,
  parameter int IN_W  = 8,
  parameter int OBS_W = 8,
  parameter int ACT_W = 8,
  parameter int CNT_W = 16,
  localparam int BIT_W = (OBS_W > 1) ? $clog2(OBS_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  stim_i,
  output logic [IN_W-1:0]  chk_stim_o,
  input  logic [OBS_W-1:0] mst_obs_i,
  input  logic [OBS_W-1:0] chk_obs_i,
  input  logic [ACT_W-1:0] act_i,
  output logic [ACT_W-1:0] act_o,
  output logic             safe_o,
  output logic             err_o,
  output logic [CNT_W-1:0] fault_cycle_o,
  output logic [BIT_W-1:0] fault_bit_o
);
  logic [OBS_W-1:0] mst_dly;
  logic             mis;
  logic [BIT_W-1:0] mis_pos;

  ls_delay_line #(.W(IN_W), .N(DLY)) u_stim_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stim_i), .q_o(chk_stim_o)
  );

  ls_delay_line #(.W(OBS_W), .N(DLY)) u_obs_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mst_obs_i), .q_o(mst_dly)
  );

  ls_diff_locate #(.W(OBS_W)) u_diff (
    .a_i(mst_dly), .b_i(chk_obs_i), .any_o(mis), .pos_o(mis_pos)
  );

  ls_fault_latch #(.DLY(DLY), .CNT_W(CNT_W), .BW(BIT_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .mis_i(mis), .pos_i(mis_pos),
    .safe_o(safe_o), .err_o(err_o), .cyc_o(fault_cycle_o), .bit_o(fault_bit_o)
  );

  // actuator cut is combinational so the first bad cycle never drives
  assign act_o = safe_o ? '0 : act_i;
endmodule

// File: rtl/lockstep_cmp_chk.sv
module lockstep_cmp_chk #(
  parameter int DLY   = 2,
  parameter int IN_W  = 8,
  parameter int OBS_W = 8,
  parameter int ACT_W = 8,
  parameter int CNT_W = 16,
  parameter int BIT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IN_W-1:0]  stim_i,
  input logic [IN_W-1:0]  chk_stim_o,
  input logic [OBS_W-1:0] mst_obs_i,
  input logic [OBS_W-1:0] chk_obs_i,
  input logic [ACT_W-1:0] act_i,
  input logic [ACT_W-1:0] act_o,
  input logic             safe_o,
  input logic             err_o,
  input logic [CNT_W-1:0] fault_cycle_o,
  input logic [BIT_W-1:0] fault_bit_o
);
  logic [2:0] n_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        n_q <= '0;
    else if (n_q != '1) n_q <= n_q + 1'b1;
  end
  assign warm = (32'(n_q) >= DLY);

  // R1
  stim_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> chk_stim_o == $past(stim_i, DLY));
  // R2
  mismatch_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(mst_obs_i, DLY) != chk_obs_i) |-> safe_o);
  // R3
  fill_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm |-> !safe_o && !err_o);
  // R4
  act_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_o |-> act_o == '0);
  // R4
  act_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !safe_o |-> act_o == act_i);
  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && safe_o);
  // R5
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(safe_o));
  // R7
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(fault_cycle_o) && $stable(fault_bit_o));
endmodule

bind lockstep_cmp lockstep_cmp_chk #(
  .DLY(DLY), .IN_W(IN_W), .OBS_W(OBS_W), .ACT_W(ACT_W), .CNT_W(CNT_W), .BIT_W(BIT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stim_i(stim_i), .chk_stim_o(chk_stim_o),
  .mst_obs_i(mst_obs_i), .chk_obs_i(chk_obs_i), .act_i(act_i), .act_o(act_o),
  .safe_o(safe_o), .err_o(err_o), .fault_cycle_o(fault_cycle_o),
  .fault_bit_o(fault_bit_o)
);

// File: tb/lockstep_cmp_test.sv
module lockstep_cmp_test;
  localparam int DLY = 2, IN_W = 8, OBS_W = 8, ACT_W = 8, CNT_W = 16, BIT_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [IN_W-1:0]  stim = '0;
  logic [ACT_W-1:0] act = '0;
  logic [OBS_W-1:0] inj = '0;
  logic [IN_W-1:0]  chk_stim;
  logic [OBS_W-1:0] obs_m, obs_c;
  logic [ACT_W-1:0] act_out;
  logic safe, err;
  logic [CNT_W-1:0] fcyc;
  logic [BIT_W-1:0] fbit;
  logic [7:0] acc_m, acc_c;
  logic [IN_W-1:0] hist [64];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] core_f(input logic [7:0] s, input logic [7:0] a);
    return {a[3:0] ^ s[7:4], s[3:0] + a[7:4]};
  endfunction

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin acc_m <= '0; acc_c <= '0; end
    else begin acc_m <= acc_m + stim; acc_c <= acc_c + chk_stim; end
  end
  assign obs_m = core_f(stim, acc_m);
  assign obs_c = core_f(chk_stim, acc_c) ^ inj;

  lockstep_cmp #(.DLY(DLY), .IN_W(IN_W), .OBS_W(OBS_W), .ACT_W(ACT_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .stim_i(stim), .chk_stim_o(chk_stim),
    .mst_obs_i(obs_m), .chk_obs_i(obs_c), .act_i(act), .act_o(act_out),
    .safe_o(safe), .err_o(err), .fault_cycle_o(fcyc), .fault_bit_o(fbit)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] stim_f(input int t, input int seed);
    return 8'(t * 37 + seed * 13 + 5);
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; inj = '0; stim = '0; act = '0;
    repeat (2) @(negedge clk);
    #1;
    check("R8 err after reset", 32'(err), 0);
    check("R8 safe after reset", 32'(safe), 0);
    check("R8 chk_stim after reset", 32'(chk_stim), 0);
    check("R8 record after reset", {16'(fcyc), 16'(fbit)}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one run: inject mask m1 at cycle k1 and m2 at cycle k2 (m=0 means none)
  task automatic run(input int len, input int seed, input int k1, input logic [7:0] m1,
                     input int k2, input logic [7:0] m2, input bit chk_align);
    for (int t = 0; t < len; t++) begin
      stim = stim_f(t, seed);
      hist[t] = stim;
      act = 8'(seed * 29 + t) | 8'h01;
      inj = (t == k1) ? m1 : ((t == k2) ? m2 : '0);
      #1;
      if (chk_align)
        check("R1 delayed stimulus", 32'(chk_stim), (t < DLY) ? 0 : 32'(hist[t-DLY]));
      if (t == k1 && m1 != 0) begin
        check("R3/R4 safe in fault cycle", 32'(safe), 32'(k1 >= DLY));
        check("R4 actuator in fault cycle", 32'(act_out), (k1 >= DLY) ? 0 : 32'(act));
      end
      if (t == k1 + 1 && m1 != 0 && k1 >= DLY)
        check("R5 err one edge after fault", 32'(err), 1);
      @(negedge clk);
    end
    inj = '0;
  endtask

  initial begin
    do_reset();
    run(40, 1, -1, 8'h00, -1, 8'h00, 1);
    check("R2 no false alarm", 32'(err), 0);
    check("R4 actuator passes", 32'(act_out), 32'(act));

    // R2 R3 R6 R7: sweep fault cycle and bit
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < OBS_W; b++) begin
        do_reset();
        run(k + 4, k * 8 + b, k, 8'(1 << b), -1, 8'h00, 0);
        check("R5 err state", 32'(err), 32'(k >= DLY));
        check("R5 safe held", 32'(safe), 32'(k >= DLY));
        check("R6 fault cycle", 32'(fcyc), (k >= DLY) ? 32'(k) : 0);
        check("R7 fault bit", 32'(fbit), (k >= DLY) ? 32'(b) : 0);
      end
    end

    // R7: multi-bit picks lowest, later fault ignored
    do_reset();
    run(12, 3, 4, 8'b1011_0100, 7, 8'h01, 0);
    check("R7 lowest bit of multi-bit", 32'(fbit), 2);
    check("R7 later fault keeps cycle", 32'(fcyc), 4);
    check("R4 actuator cut while safe", 32'(act_out), 0);

    // R8: reset clears a latched fault
    do_reset();
    check("R8 err cleared", 32'(err), 0);
    run(10, 9, -1, 8'h00, -1, 8'h00, 1);
    check("R8 clean after clear", 32'(err), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule